// File: doc/BRIEF.md
# Serial-Bus Control and Status Slave for a Two-Output AV Switch

This block is the control port of a two-output audio/video switch. It sits on a two-wire serial bus (I2C) as a target device. A bus master writes one control byte for each switch output, and the block holds each byte in a register that drives the analog switching. The master can also read back one status byte. That byte reports whether the part has been through a power-on reset since the last read, and what level each of two sense pins is at.

The device address comes from a strap pin, so two switches can share one bus. SCL and SDA are sampled on the system clock through synchronizers, and all bus decoding runs in that clock domain. The open-drain SDA line is split into an input and a pull-low enable. The two sense pins arrive already digitized, each as a pair of comparator outputs, one at a low threshold and one at a high threshold. The block turns each pair into an "open" flag and a "grounded" flag.

Top module: `avsw_i2c_ctrl`

## Requirements
- R1: While `rst` is high and after it, both control outputs are 0x00 and `sda_oe` is low until the next addressed transfer.
- R2: The 8-bit write address is 0x90 with `adr_sel` low and 0x92 with it high; the read addresses are 0x91 and 0x93. The block acknowledges only its own address. For any other address it leaves SDA released and its registers untouched until the next START.
- R3: Bytes are shifted MSB first. In a write frame, the first data byte after the address goes to `ctrl_out1` and the second goes to `ctrl_out2`. Bit 7 of each byte is the audio gain select for that output, and each register takes its byte at the end of the byte's eighth bit.
- R4: The third and later data bytes of a write frame are acknowledged and change neither control output.
- R5: Status bit 7 reads 1 from reset until the first read address is acknowledged. That first read returns 1, and every later status byte returns 0 until the next reset.
- R6: Status bits 6/5 give sense pin 1 as open/grounded and bits 4/3 give sense pin 2; bits 2..0 read 0. Each comparator pair is given as {above_high, above_low}. The code 00 (low level) gives open=0, grounded=1. The code 01 (mid level) gives 0,0. The code 11 (high level) gives 1,0.
- R7: The block pulls SDA low in the acknowledge clock of its address and of every write data byte. It releases SDA for the master's acknowledge after each status byte. A not-acknowledge from the master ends the read, and SDA stays released until the next START.
- R8: A STOP or START anywhere in a frame abandons it. A partly received byte is discarded, and a new START restarts the data byte count at output 1.
- R9: If the master acknowledges a status byte, the block sends the status byte again with bit 7 now 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Power-on reset strobe, synchronous, active high |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull the data line low when 1 |
| adr_sel | input | 1 | Address strap: low selects 0x90/0x91, high selects 0x92/0x93 |
| sense1_cmp | input | 2 | Sense pin 1 comparators {above_high, above_low} |
| sense2_cmp | input | 2 | Sense pin 2 comparators {above_high, above_low} |
| ctrl_out1 | output | 8 | Control register for switch output 1 |
| ctrl_out2 | output | 8 | Control register for switch output 2 |

## Verification
A byte counter or shift register in the wrong state shows up at the ports within one byte time. Either a missing or extra acknowledge appears on `sda_oe` at the ninth clock, or the wrong control output changes at the end of that byte. A power-on flag that does not clear is seen on the second status byte of a read that the master acknowledges. A misdecoded comparator pair shows up in the first status byte read after the sense inputs change. Aborted frames are checked by reading both control outputs after a STOP that lands in the middle of a byte.

// File: rtl/avsw_pkg.sv
package avsw_pkg;
  localparam int BYTE_W     = 8;
  localparam int CTRL_BYTES = 2;
  localparam int N_SENSE    = 2;
  localparam int IDX_W      = $clog2(CTRL_BYTES + 1);
  localparam int CNT_W      = $clog2(BYTE_W + 1);
  localparam logic [5:0] DEV_ADDR_HI = 6'b100100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_RLOAD
  } bus_state_t;
endpackage

// File: rtl/avsw_sync.sv
module avsw_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/avsw_bus_events.sv
module avsw_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/avsw_status_enc.sv
module avsw_status_enc
  import avsw_pkg::*;
#(
  parameter int NS = N_SENSE
) (
  input  logic            por_flag,
  input  logic [2*NS-1:0] cmp,
  output logic [7:0]      stat
);
  localparam int PAD = 7 - 2*NS;

  logic [2*NS-1:0] fld;

  for (genvar k = 0; k < NS; k++) begin : g_sense
    // field pair for sense k: {open, grounded}, sense 0 in the upper pair
    assign fld[2*(NS-1-k)+1] = cmp[2*k+1];
    assign fld[2*(NS-1-k)]   = ~cmp[2*k] & ~cmp[2*k+1];
  end

  assign stat = {por_flag, fld, {PAD{1'b0}}};
endmodule

// File: rtl/avsw_i2c_ctrl.sv
module avsw_i2c_ctrl
  import avsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       adr_sel,
  input  logic [1:0] sense1_cmp,
  input  logic [1:0] sense2_cmp,
  output logic [7:0] ctrl_out1,
  output logic [7:0] ctrl_out2
);
  localparam int SIDE_W = 1 + 2*N_SENSE;

  logic             scl_s, sda_s;
  logic [SIDE_W-1:0] side_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]       status_byte;
  logic             por_flag;

  bus_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic             rw;
  logic [IDX_W-1:0] byte_idx;
  logic             commit;
  logic [7:0]       ctrl_q [CTRL_BYTES];

  avsw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
    .clk (clk), .rst (rst), .d ({scl_i, sda_i}), .q ({scl_s, sda_s})
  );

  avsw_sync #(.W(SIDE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_side_sync (
    .clk (clk), .rst (rst), .d ({adr_sel, sense2_cmp, sense1_cmp}), .q (side_s)
  );

  avsw_bus_events u_events (
    .clk (clk), .rst (rst), .scl_s (scl_s), .sda_s (sda_s),
    .scl_rise (scl_rise), .scl_fall (scl_fall),
    .start_det (start_det), .stop_det (stop_det)
  );

  avsw_status_enc #(.NS(N_SENSE)) u_status (
    .por_flag (por_flag), .cmp (side_s[2*N_SENSE-1:0]), .stat (status_byte)
  );

  assign commit = (state == ST_WR) && scl_fall && (cnt == CNT_W'(BYTE_W))
                  && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
      por_flag <= 1'b1;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
            if (shreg[7:1] == {DEV_ADDR_HI, side_s[SIDE_W-1]}) begin
              rw     <= shreg[0];
              sda_oe <= 1'b1;
              state  <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg    <= status_byte;
              sda_oe   <= ~status_byte[7];
              cnt      <= CNT_W'(1);
              por_flag <= 1'b0;
              state    <= ST_RD;
            end else begin
              sda_oe   <= 1'b0;
              cnt      <= '0;
              byte_idx <= '0;
              state    <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (commit) begin
            if (byte_idx != IDX_W'(CTRL_BYTES)) byte_idx <= byte_idx + 1'b1;
            sda_oe <= 1'b1;
            state  <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt != CNT_W'(BYTE_W)) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              cnt    <= cnt + 1'b1;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) state <= sda_s ? ST_IDLE : ST_RLOAD;
        end
        ST_RLOAD: begin
          if (scl_fall) begin
            shreg  <= status_byte;
            sda_oe <= ~status_byte[7];
            cnt    <= CNT_W'(1);
            state  <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CTRL_BYTES; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)                                   ctrl_q[g] <= '0;
      else if (commit && byte_idx == IDX_W'(g))  ctrl_q[g] <= shreg;
    end
  end

  assign ctrl_out1 = ctrl_q[0];
  assign ctrl_out2 = ctrl_q[1];
endmodule

// File: rtl/avsw_i2c_ctrl_chk.sv
module avsw_i2c_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic [7:0] ctrl_out1,
  input logic [7:0] ctrl_out2,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       por_flag
);
  // R1: registers and SDA drive are clear right after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) && !rst |-> ctrl_out1 == 8'h00 && ctrl_out2 == 8'h00 && !sda_oe);

  // R3 and R4: output 1 only changes together with the start of an acknowledge
  a_r3_ctrl1_with_ack: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$stable(ctrl_out1) |-> $rose(sda_oe));

  // R3 and R4: output 2 only changes together with the start of an acknowledge
  a_r4_ctrl2_with_ack: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$stable(ctrl_out2) |-> $rose(sda_oe));

  // R7: SDA drive changes only while the bus clock is low or on a bus condition
  a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$stable(sda_oe) |-> $past(!scl_s || start_det || stop_det));

  // R8: a STOP always leaves SDA released
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R5: once cleared, the power-on flag stays cleared until reset
  a_r5_por_sticky_clear: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(!por_flag) |-> !por_flag);
endmodule

bind avsw_i2c_ctrl avsw_i2c_ctrl_chk u_chk (.*);

// File: tb/tb_avsw_i2c_ctrl.sv
module tb_avsw_i2c_ctrl;
  localparam int Q = 8;  // system clocks per quarter bus bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       adr_sel = 1'b0;
  logic [1:0] sense1_cmp = 2'b00;
  logic [1:0] sense2_cmp = 2'b00;
  logic [7:0] ctrl_out1, ctrl_out2;
  logic       sda_line;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  avsw_i2c_ctrl dut (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_line), .sda_oe (sda_oe),
    .adr_sel (adr_sel), .sense1_cmp (sense1_cmp), .sense2_cmp (sense2_cmp),
    .ctrl_out1 (ctrl_out1), .ctrl_out2 (ctrl_out2)
  );

  // {adr_sel, addr, data1, data2, expect_ack, expect_ctrl1, expect_ctrl2}
  localparam int NV = 5;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 8'h90, 8'hA5, 8'h3C, 1'b1, 8'hA5, 8'h3C},
    {1'b0, 8'h92, 8'hFF, 8'hFF, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'h92, 8'h81, 8'h7E, 1'b1, 8'h81, 8'h7E},
    {1'b1, 8'h90, 8'h00, 8'h00, 1'b0, 8'h81, 8'h7E},
    {1'b0, 8'h90, 8'h5A, 8'hC3, 1'b1, 8'h5A, 8'hC3}
  };

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b1; waitq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; waitq(1);
      scl_m = 1'b1; waitq(2);
      scl_m = 1'b0; waitq(1);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    ack = ~sda_line; waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic rd_byte(input logic master_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(1);
      scl_m = 1'b1; waitq(1);
      d[i] = sda_line; waitq(1);
      scl_m = 1'b0; waitq(1);
    end
    sda_m = ~master_ack; waitq(1);
    scl_m = 1'b1; waitq(2);
    scl_m = 1'b0; waitq(1);
    sda_m = 1'b1;
  endtask

  function automatic logic [1:0] enc(input logic [1:0] c);
    case (c)
      2'b00:   return 2'b01;
      2'b01:   return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(input logic p, input logic [1:0] a, input logic [1:0] b);
    return {p, enc(a), enc(b), 3'b000};
  endfunction

  initial begin
    repeat (SAFE_LIMIT()) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  function automatic int SAFE_LIMIT();
    return 180000;
  endfunction

  initial begin
    logic       ack;
    logic [7:0] d;

    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 ctrl1 at reset", ctrl_out1, 8'h00);
    chk("R1 ctrl2 at reset", ctrl_out2, 8'h00);
    chk("R1 sda released at reset", {7'd0, sda_oe}, 8'h00);
    rst = 1'b0;
    waitq(2);

    // R5 R6 R9: first read carries the power-on flag; acknowledged second byte has it cleared
    sense1_cmp = 2'b00; sense2_cmp = 2'b11;
    waitq(1);
    bus_start();
    wr_byte(8'h91, ack);
    chk("R2 read address 0x91 acked", {7'd0, ack}, 8'h01);
    rd_byte(1'b1, d);
    chk("R5 R6 first status byte", d, exp_stat(1'b1, 2'b00, 2'b11));
    rd_byte(1'b0, d);
    chk("R9 second status byte after master ack", d, exp_stat(1'b0, 2'b00, 2'b11));
    chk("R7 sda released after master nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R6: mid level on pin 1, low level on pin 2
    sense1_cmp = 2'b01; sense2_cmp = 2'b00;
    waitq(1);
    bus_start();
    wr_byte(8'h91, ack);
    rd_byte(1'b0, d);
    chk("R5 R6 later status byte", d, exp_stat(1'b0, 2'b01, 2'b00));
    bus_stop();

    // R2 R3 R7: vector table of write frames
    for (int v = 0; v < NV; v++) begin
      adr_sel = VEC[v][41];
      waitq(1);
      bus_start();
      wr_byte(VEC[v][40:33], ack);
      chk("R2 address acknowledge", {7'd0, ack}, {7'd0, VEC[v][16]});
      wr_byte(VEC[v][32:25], ack);
      if (VEC[v][16]) chk("R7 data byte 1 acked", {7'd0, ack}, 8'h01);
      wr_byte(VEC[v][24:17], ack);
      bus_stop();
      chk("R3 ctrl1 after frame", ctrl_out1, VEC[v][15:8]);
      chk("R3 ctrl2 after frame", ctrl_out2, VEC[v][7:0]);
    end

    // R2: read address with strap high
    adr_sel = 1'b1; sense1_cmp = 2'b11; sense2_cmp = 2'b01;
    waitq(1);
    bus_start();
    wr_byte(8'h91, ack);
    chk("R2 0x91 not acked with strap high", {7'd0, ack}, 8'h00);
    bus_stop();
    bus_start();
    wr_byte(8'h93, ack);
    chk("R2 0x93 acked with strap high", {7'd0, ack}, 8'h01);
    rd_byte(1'b0, d);
    chk("R6 status with strap high", d, exp_stat(1'b0, 2'b11, 2'b01));
    bus_stop();

    // R4: extra bytes acknowledged and ignored
    adr_sel = 1'b0;
    waitq(1);
    bus_start();
    wr_byte(8'h90, ack);
    wr_byte(8'h11, ack);
    wr_byte(8'h22, ack);
    wr_byte(8'h33, ack);
    chk("R4 third data byte acked", {7'd0, ack}, 8'h01);
    wr_byte(8'h44, ack);
    chk("R4 fourth data byte acked", {7'd0, ack}, 8'h01);
    bus_stop();
    chk("R4 ctrl1 keeps first byte", ctrl_out1, 8'h11);
    chk("R4 ctrl2 keeps second byte", ctrl_out2, 8'h22);

    // R8: STOP inside a byte discards it
    bus_start();
    wr_byte(8'h90, ack);
    send_bits(8'hF0, 4);
    bus_stop();
    chk("R8 ctrl1 unchanged after mid-byte stop", ctrl_out1, 8'h11);
    chk("R8 ctrl2 unchanged after mid-byte stop", ctrl_out2, 8'h22);

    // R8: repeated START restarts the byte count at output 1
    bus_start();
    wr_byte(8'h90, ack);
    wr_byte(8'h66, ack);
    bus_start();
    wr_byte(8'h90, ack);
    wr_byte(8'hEE, ack);
    bus_stop();
    chk("R8 ctrl1 from restarted frame", ctrl_out1, 8'hEE);
    chk("R8 ctrl2 untouched by restart", ctrl_out2, 8'h22);

    // R1 R5: a fresh reset clears registers and re-arms the power-on flag
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    waitq(2);
    chk("R1 ctrl1 after second reset", ctrl_out1, 8'h00);
    chk("R1 ctrl2 after second reset", ctrl_out2, 8'h00);
    sense1_cmp = 2'b01; sense2_cmp = 2'b01;
    waitq(1);
    bus_start();
    wr_byte(8'h91, ack);
    rd_byte(1'b0, d);
    chk("R5 flag set again after reset", d, exp_stat(1'b1, 2'b01, 2'b01));
    bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule